// File: doc/BRIEF.md
# Clock Synthesizer Reconfiguration Controller

This block reprograms the multiply/divide ratio of a running frequency-synthesizing clock unit through that unit's register-write port. A pulse on `start_i`, taken only while the controller is idle, selects one of three output frequencies through `mode_sel_i`. The three targets are 245.76 MHz, 256 MHz and 179.2 MHz, one for each active radio mode. The controller then steps through a fixed sequence. It puts the synthesizer into reset and issues one write of a word holding the new multiplier and divisor. It waits for the port to acknowledge, takes the synthesizer out of reset, and then waits for the lock indication before it reports completion.

The multiplier, divisor and port address for each select value come from a parameter table inside the block. Lock must be seen within a cycle budget given on `lock_limit_i`. If it is not, the controller raises a sticky error flag instead of signalling completion and goes back to idle. The synthesized clock must not be used until `done_o` has pulsed.

Top module: `clk_reconfig_ctrl`

## Requirements
- R1: After reset, every output is low. `port_addr_o` and `port_wdata_o` are zero.
- R2: A high `start_i` sampled at a clock edge while idle (busy and done both low) starts a sequence, and `busy_o` is high after that edge. The value of `mode_sel_i` at that edge picks the table entry.
- R3: The written word carries the multiplier in bits [15:8] and the divisor in bits [7:0]. With the default table: select 0 gives 0x3B18 at address 0x50, select 1 gives 0x4019 at address 0x51, and select 2 gives 0x2B18 at address 0x52. Select 3 uses entry 0.
- R4: Each sequence raises `port_en_o` and `port_we_o` together for exactly one cycle, and `synth_rst_o` is high in that cycle.
- R5: `synth_rst_o` is high for the first cycle after acceptance, for the write cycle and for every ready-wait cycle. It is then low until the next sequence starts.
- R6: The controller waits for `port_rdy_i`, including the cycle in which ready is sampled high. The synthesizer reset is released only after that.
- R7: After a one-cycle release step the controller samples `lock_i`. The cycle after lock is sampled high, `done_o` is high for one cycle and `busy_o` is low. Busy lasts 3 cycles plus the ready-wait cycles plus the lock-wait cycles, where each wait counts the cycle its handshake is sampled in.
- R8: `start_i` has no effect while busy is high or while done is high.
- R9: If lock is not sampled high within `lock_limit_i` lock-wait cycles (a limit of 0 acts as 1), `err_o` is set and the controller returns to idle without pulsing `done_o`.
- R10: `err_o` stays high until the next accepted start, which clears it.
- R11: Changes on `mode_sel_i` after acceptance do not change the address or the data of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin reprogramming |
| mode_sel_i | input | 2 | Target frequency select |
| port_rdy_i | input | 1 | Write acknowledge from the synthesizer port |
| lock_i | input | 1 | Synthesizer lock indication |
| lock_limit_i | input | 16 | Lock-wait budget in cycles |
| port_addr_o | output | 7 | Port register address |
| port_en_o | output | 1 | Port access enable |
| port_we_o | output | 1 | Port write enable |
| port_wdata_o | output | 16 | Multiplier and divisor word |
| synth_rst_o | output | 1 | Reset to the synthesizer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Lock timeout flag |

## Verification
A state register that skips or repeats a step shows up at once in the per-run counts: the number of enable cycles, the number of cycles with the synthesizer held in reset, and the length of busy. Each of these is compared with an exact formula in the ready and lock latencies. A wrong latch of the select appears in the captured write word or address of the same run. A wrong timeout comparison appears as `done_o` and `err_o` being swapped on the first lock latency that lies next to the limit. The sweep runs these latencies right at the limit and one cycle past it.

// File: rtl/clkrc_pkg.sv
package clkrc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ASSERT_RST,
      ST_WRITE,
      ST_WAIT_RDY,
      ST_RELEASE_RST,
      ST_WAIT_LOCK,
      ST_DONE
   } clkrc_state_e;

endpackage

// File: rtl/clkrc_mode_table.sv
module clkrc_mode_table #(
   parameter int NUM_MODES = 3,
   parameter int SEL_W     = 2,
   parameter int MULT_W    = 8,
   parameter int DIV_W     = 8,
   parameter int ADDR_W    = 7,
   parameter logic [NUM_MODES*MULT_W-1:0] MULT_TAB = '0,
   parameter logic [NUM_MODES*DIV_W-1:0]  DIV_TAB  = '0,
   parameter logic [NUM_MODES*ADDR_W-1:0] ADDR_TAB = '0
) (
   input  logic [SEL_W-1:0]  sel_i,
   output logic [MULT_W-1:0] mult_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [ADDR_W-1:0] addr_o
);

   logic [MULT_W-1:0] mult_a [NUM_MODES];
   logic [DIV_W-1:0]  div_a  [NUM_MODES];
   logic [ADDR_W-1:0] addr_a [NUM_MODES];

   // unpack the flat parameter vectors, one entry per mode
   for (genvar i = 0; i < NUM_MODES; i++) begin : g_entry
      assign mult_a[i] = MULT_TAB[i*MULT_W +: MULT_W];
      assign div_a[i]  = DIV_TAB[i*DIV_W +: DIV_W];
      assign addr_a[i] = ADDR_TAB[i*ADDR_W +: ADDR_W];
   end

   // entry 0 is the fallback for unused select codes
   always_comb begin
      mult_o = mult_a[0];
      div_o  = div_a[0];
      addr_o = addr_a[0];
      for (int i = 1; i < NUM_MODES; i++) begin
         if (sel_i == SEL_W'(i)) begin
            mult_o = mult_a[i];
            div_o  = div_a[i];
            addr_o = addr_a[i];
         end
      end
   end

endmodule

// File: rtl/clkrc_lock_timer.sv
module clkrc_lock_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o
);

   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] next_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   // the current wait cycle is the last allowed one when count+1 reaches the limit
   assign next_ext = {1'b0, cnt_q} + EXT_W'(1);
   assign expire_o = run_i && (next_ext >= {1'b0, limit_i});

endmodule

// File: rtl/clkrc_seq_fsm.sv
module clkrc_seq_fsm
   import clkrc_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rdy_i,
   input  logic              lock_i,
   input  logic              expire_i,
   input  logic [WORD_W-1:0] tab_word_i,
   input  logic [ADDR_W-1:0] tab_addr_i,
   output logic              timer_run_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [WORD_W-1:0] wdata_o,
   output logic              en_o,
   output logic              we_o,
   output logic              synth_rst_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   clkrc_state_e state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] word_q;
   logic              err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         word_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_ASSERT_RST;
                  addr_q  <= tab_addr_i;
                  word_q  <= tab_word_i;
                  err_q   <= 1'b0;
               end
            end
            ST_ASSERT_RST:  state_q <= ST_WRITE;
            ST_WRITE:       state_q <= ST_WAIT_RDY;
            ST_WAIT_RDY: begin
               if (rdy_i) state_q <= ST_RELEASE_RST;
            end
            ST_RELEASE_RST: state_q <= ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
               if (lock_i) begin
                  state_q <= ST_DONE;
               end else if (expire_i) begin
                  state_q <= ST_IDLE;
                  err_q   <= 1'b1;
               end
            end
            ST_DONE:        state_q <= ST_IDLE;
            default:        state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      en_o        = (state_q == ST_WRITE);
      we_o        = (state_q == ST_WRITE);
      synth_rst_o = (state_q == ST_ASSERT_RST) || (state_q == ST_WRITE) ||
                    (state_q == ST_WAIT_RDY);
      busy_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
      done_o      = (state_q == ST_DONE);
      timer_run_o = (state_q == ST_WAIT_LOCK);
   end

   assign addr_o  = addr_q;
   assign wdata_o = word_q;
   assign err_o   = err_q;

endmodule

// File: rtl/clk_reconfig_ctrl.sv
module clk_reconfig_ctrl #(
   parameter int NUM_MODES = 3,
   parameter int SEL_W     = 2,
   parameter int MULT_W    = 8,
   parameter int DIV_W     = 8,
   parameter int ADDR_W    = 7,
   parameter int CNT_W     = 16,
   parameter logic [NUM_MODES*MULT_W-1:0] MULT_TAB = {8'd43, 8'd64, 8'd59},
   parameter logic [NUM_MODES*DIV_W-1:0]  DIV_TAB  = {8'd24, 8'd25, 8'd24},
   parameter logic [NUM_MODES*ADDR_W-1:0] ADDR_TAB = {7'h52, 7'h51, 7'h50},
   localparam int WORD_W = MULT_W + DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [SEL_W-1:0]  mode_sel_i,
   input  logic              port_rdy_i,
   input  logic              lock_i,
   input  logic [CNT_W-1:0]  lock_limit_i,
   output logic [ADDR_W-1:0] port_addr_o,
   output logic              port_en_o,
   output logic              port_we_o,
   output logic [WORD_W-1:0] port_wdata_o,
   output logic              synth_rst_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   // elaboration-time parameter checks
   if (NUM_MODES < 1 || NUM_MODES > (1 << SEL_W)) begin : g_bad_modes
      $error("clk_reconfig_ctrl: NUM_MODES does not fit SEL_W");
   end
   if (MULT_W < 1 || DIV_W < 1 || ADDR_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("clk_reconfig_ctrl: field widths must be positive");
   end

   logic [MULT_W-1:0] tab_mult;
   logic [DIV_W-1:0]  tab_div;
   logic [ADDR_W-1:0] tab_addr;
   logic              timer_run;
   logic              expire;

   clkrc_mode_table #(
      .NUM_MODES (NUM_MODES),
      .SEL_W     (SEL_W),
      .MULT_W    (MULT_W),
      .DIV_W     (DIV_W),
      .ADDR_W    (ADDR_W),
      .MULT_TAB  (MULT_TAB),
      .DIV_TAB   (DIV_TAB),
      .ADDR_TAB  (ADDR_TAB)
   ) u_table (
      .sel_i  (mode_sel_i),
      .mult_o (tab_mult),
      .div_o  (tab_div),
      .addr_o (tab_addr)
   );

   clkrc_lock_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (timer_run),
      .limit_i  (lock_limit_i),
      .expire_o (expire)
   );

   clkrc_seq_fsm #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rdy_i       (port_rdy_i),
      .lock_i      (lock_i),
      .expire_i    (expire),
      .tab_word_i  ({tab_mult, tab_div}),
      .tab_addr_i  (tab_addr),
      .timer_run_o (timer_run),
      .addr_o      (port_addr_o),
      .wdata_o     (port_wdata_o),
      .en_o        (port_en_o),
      .we_o        (port_we_o),
      .synth_rst_o (synth_rst_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o)
   );

endmodule

// File: rtl/clkrc_checker.sv
module clkrc_checker #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              port_rdy_i,
   input logic              lock_i,
   input logic [ADDR_W-1:0] port_addr_o,
   input logic              port_en_o,
   input logic              port_we_o,
   input logic [WORD_W-1:0] port_wdata_o,
   input logic              synth_rst_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o
);

   a_r2_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !done_o) |=> busy_o);

   a_r4_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      port_en_o |-> (port_we_o && synth_rst_o && busy_o));

   a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      port_en_o |=> !port_en_o);

   a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && synth_rst_o && !port_en_o && !port_rdy_i) |=> synth_rst_o);

   a_r7_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(lock_i) && !busy_o && !synth_rst_o));

   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_err_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !done_o);

   a_r11_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(port_wdata_o) && $stable(port_addr_o)));

endmodule

bind clk_reconfig_ctrl clkrc_checker #(
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .port_rdy_i   (port_rdy_i),
   .lock_i       (lock_i),
   .port_addr_o  (port_addr_o),
   .port_en_o    (port_en_o),
   .port_we_o    (port_we_o),
   .port_wdata_o (port_wdata_o),
   .synth_rst_o  (synth_rst_o),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .err_o        (err_o)
);

// File: tb/clk_reconfig_ctrl_bench.sv
`timescale 1ns/1ps
module clk_reconfig_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  mode_sel_i = 2'd0;
   logic        port_rdy_i;
   logic        lock_i;
   logic [15:0] lock_limit_i = 16'd4;
   logic [6:0]  port_addr_o;
   logic        port_en_o, port_we_o, synth_rst_o, busy_o, done_o, err_o;
   logic [15:0] port_wdata_o;

   int tests = 0;
   int fails = 0;
   int m_rl = 0;
   int m_ll = 0;

   always #2.5 clk = ~clk;

   clk_reconfig_ctrl u_clk_reconfig_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_sel_i(mode_sel_i),
      .port_rdy_i(port_rdy_i), .lock_i(lock_i), .lock_limit_i(lock_limit_i),
      .port_addr_o(port_addr_o), .port_en_o(port_en_o), .port_we_o(port_we_o),
      .port_wdata_o(port_wdata_o), .synth_rst_o(synth_rst_o), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o));

   // behavioural synthesizer: ready m_rl cycles after the write, lock m_ll cycles after reset release
   logic ron;
   int   rcnt, lcnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         port_rdy_i <= 1'b0; ron <= 1'b0; rcnt <= 0; lock_i <= 1'b0; lcnt <= 0;
      end else begin
         port_rdy_i <= 1'b0;
         if (port_en_o && port_we_o) begin
            ron <= 1'b1; rcnt <= m_rl;
         end else if (ron) begin
            if (rcnt == 0) begin port_rdy_i <= 1'b1; ron <= 1'b0; end
            else rcnt <= rcnt - 1;
         end
         if (synth_rst_o) begin
            lock_i <= 1'b0; lcnt <= 0;
         end else if (!lock_i) begin
            if (lcnt == m_ll) lock_i <= 1'b1;
            else lcnt <= lcnt + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input int sel);
      int m, d;
      case (sel)
         1: begin m = 64; d = 25; end
         2: begin m = 43; d = 24; end
         default: begin m = 59; d = 24; end
      endcase
      return 16'(m * 256 + d);
   endfunction

   function automatic logic [6:0] exp_addr(input int sel);
      return (sel == 1 || sel == 2) ? 7'(8'h50 + sel) : 7'h50;
   endfunction

   task automatic run_seq(input int sel, input int rl, input int ll, input int limit,
                          input bit inject, input bit flip_sel);
      int en_cnt = 0, rst_cnt = 0, busy_cnt = 0, n = 0, eff;
      bit we_ok = 1'b1, rst_ok = 1'b1, ok;
      logic [15:0] cap_w = '0;
      logic [6:0]  cap_a = '0;
      m_rl = rl; m_ll = ll;
      lock_limit_i = 16'(limit);
      @(negedge clk);
      mode_sel_i = 2'(sel);
      start_i = 1'b1;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            start_i = 1'b0;
            check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
            if (flip_sel) mode_sel_i = ~mode_sel_i;
         end
         if (inject && n == 3) start_i = 1'b1;
         if (inject && n == 4) start_i = 1'b0;
         if (port_en_o) begin
            en_cnt++;
            cap_w = port_wdata_o; cap_a = port_addr_o;
            if (!port_we_o) we_ok = 1'b0;
            if (!synth_rst_o) rst_ok = 1'b0;
         end
         if (synth_rst_o) rst_cnt++;
         if (!busy_o || n > 2000) break;
         busy_cnt++;
      end
      eff = (limit == 0) ? 1 : limit;
      ok  = (ll < eff);
      check(en_cnt == 1, "R4 write count", en_cnt, 1);
      check(we_ok && rst_ok, "R4 strobes with reset", {we_ok, rst_ok}, 2'b11);
      check(cap_w == exp_word(sel), "R3 write word", cap_w, exp_word(sel));
      check(cap_a == exp_addr(sel), "R3 address", cap_a, exp_addr(sel));
      check(rst_cnt == rl + 4, "R5 R6 reset cycles", rst_cnt, rl + 4);
      check(synth_rst_o == 1'b0, "R5 reset released at end", synth_rst_o, 0);
      if (ok) begin
         check(busy_cnt == rl + ll + 6, "R7 busy length", busy_cnt, rl + ll + 6);
         check(done_o == 1'b1 && err_o == 1'b0, "R7 R10 done no err", {done_o, err_o}, 2'b10);
         if (inject) start_i = 1'b1;     // start during done: ignored (R8)
         @(negedge clk);
         start_i = 1'b0;
         check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
         @(negedge clk);
         check(busy_o == 1'b0 && port_en_o == 1'b0, "R8 start in done ignored",
               {busy_o, port_en_o}, 0);
      end else begin
         check(busy_cnt == rl + 5 + eff, "R9 busy length on timeout", busy_cnt, rl + 5 + eff);
         check(err_o == 1'b1 && done_o == 1'b0, "R9 timeout flag", {err_o, done_o}, 2'b10);
         @(negedge clk);
         check(err_o == 1'b1 && done_o == 1'b0, "R10 err held", {err_o, done_o}, 2'b10);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(port_en_o == 0 && port_we_o == 0 && synth_rst_o == 0 && busy_o == 0 &&
            done_o == 0 && err_o == 0 && port_wdata_o == 0 && port_addr_o == 0,
            "R1 reset state", {port_en_o, port_we_o, synth_rst_o, busy_o, done_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int sel = 0; sel < 4; sel++)
         for (int rl = 0; rl < 3; rl++)
            for (int ll = 0; ll < 3; ll++)
               for (int li = 0; li < 5; li++) begin
                  int lims[5] = '{0, 1, 2, 3, 5};
                  run_seq(sel, rl, ll, lims[li], rl == 1, ll == 1);   // R8 R11 variants
               end
      run_seq(2, 3, 1000, 40, 1'b0, 1'b1);   // lock never arrives
      run_seq(1, 0, 2, 3, 1'b1, 1'b0);       // R10: clear after error
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule